// File: doc/BRIEF.md
# Serial Configuration Write Port

This block takes a three-wire, write-only configuration stream and turns it into a small bank of 8-bit control registers. The stream has three lines: an active-low frame enable, a serial clock and serial data. All three are resampled by the block's system clock, and rising edges of the serial clock are found from those samples. While the enable is low, the block shifts in one data bit on each serial-clock rising edge. It counts these edges with a counter that stops at the frame length. When the enable returns high, the block commits the frame, but only if at least a full frame of edges arrived.

Each frame is 16 bits long and is sent MSB first. The five leading bits are padding and the block ignores them. A 3-bit register address follows, then 8 data bits. The bank has four registers. Register 0 carries a soft-reset bit. While that bit is 0, the other three registers stay at their defaults and writes to them have no effect. The decoded register fields go to the neighbouring blocks. The frame enable is also passed back out, so that the pin-sharing logic outside this block can turn its output drivers around.

Top module: `cfgser_port`

## Requirements
- R1: After the hard reset `rst_n` is released, register 0 reads 00h, register 1 reads 80h (so `offset_code` = 80h), register 2 reads 00h and register 3 reads 00h. As a result, `run` and `power_up` both start at 0.
- R2: The data line is sampled only at serial-clock rising edges that occur while `ser_en_n` is low. Serial-clock edges while `ser_en_n` is high change nothing.
- R3: A frame takes effect only after `ser_en_n` rises, and at most once per enable-low window. The outputs keep their old values while the enable is still low, even after 16 edges have arrived.
- R4: If a window contains more than 16 rising edges, only the last 16 bits form the frame.
- R5: A window with fewer than 16 rising edges changes no register.
- R6: While register 0 bit 7 (the run bit) is 0, registers 1 to 3 hold their defaults, and writes to addresses 1 to 3 are dropped.
- R7: Writing register 0 with bit 7 = 0 returns registers 1 to 3 to their defaults.
- R8: The register 0 fields map as follows: bit 7 `run`, bit 5 `drive_x2`, bit 4 `cds_mode`, bits 3:2 `ft_pos`, bit 1 `dual_edge`, bit 0 `power_up`. Bit 6 is ignored.
- R9: Register 1 drives `offset_code` in full. Register 2 bits 5:0 drive `gain_code`. Register 3 maps as follows: bit 5 `tsmp_sample`, bits 4:3 `shd_width`, bit 0 `split_order`.
- R10: A frame that carries address 4 to 7 leaves every output unchanged.
- R11: Setting `power_up` to 0 keeps the contents of every register.
- R12: `out_en_n` always equals `ser_en_n`.
- R13: Frame layout, counting from the last bit shifted in as bit 0: data occupies bits 7:0, the address occupies bits 10:8, and bits 15:11 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the serial lines |
| rst_n | input | 1 | Active-low hard reset, loads every default |
| ser_en_n | input | 1 | Frame enable, low while a frame is sent |
| ser_clk | input | 1 | Serial clock; data is taken on its rising edge |
| ser_dat | input | 1 | Serial data, MSB first |
| out_en_n | output | 1 | Copy of the frame enable for the pin-sharing logic |
| run | output | 1 | Soft-reset release bit (register 0 bit 7) |
| drive_x2 | output | 1 | Doubled output drive select |
| cds_mode | output | 1 | Input mode: 0 direct-coupled, 1 correlated double sampling |
| ft_pos | output | 2 | Feed-through sample position code |
| dual_edge | output | 1 | Clock mode: 0 single edge, 1 double edge |
| power_up | output | 1 | 1 normal operation, 0 power down |
| offset_code | output | 8 | Black-level offset code |
| gain_code | output | 6 | Amplifier gain code |
| tsmp_sample | output | 1 | Data-sample pulse taken straight from the pixel pulse |
| shd_width | output | 2 | Data-sample pulse width code |
| split_order | output | 1 | Output order: 0 interleaved, 1 upper/lower byte split |

## Verification
Some rules are checked by the assertions on every cycle:
- The commit pulse lasts one cycle and never occurs while the enable is low.
- The edge counter holds once it is full.
- Registers 1 to 3 sit at their defaults whenever the run bit is 0.
- No register changes without a commit to an implemented address.

Other behaviours can only be shown by the bench's scenarios, because they concern which serial bits end up in which field:
- the MSB-first bit order and the field positions;
- the last-16-edges rule in long windows;
- dropping of short windows;
- the soft-reset ordering.

The bench checks these against a register model, using directed frames and random frames of random length.

// File: rtl/cfgser_pkg.sv
package cfgser_pkg;
   localparam int FRAME_W = 16;
   localparam int ADDR_W  = 3;
   localparam int DATA_W  = 8;
   localparam int NREG    = 4;

   // register 0 bit positions
   localparam int CTL_RUN    = 7;
   localparam int CTL_DRV    = 5;
   localparam int CTL_CDS    = 4;
   localparam int CTL_FT_LSB = 2;
   localparam int CTL_DUAL   = 1;
   localparam int CTL_PWR    = 0;
   // register 3 bit positions
   localparam int SMP_TSMP   = 5;
   localparam int SMP_W_LSB  = 3;
   localparam int SMP_SPLIT  = 0;
   localparam int GAIN_W     = 6;

   function automatic logic [DATA_W-1:0] reg_default(input int idx);
      return (idx == 1) ? DATA_W'(8'h80) : '0;
   endfunction
endpackage

// File: rtl/cfgser_sync.sv
module cfgser_sync #(
   parameter int               STAGES  = 2,
   parameter int               WIDTH   = 1,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   logic [WIDTH-1:0] stg [STAGES];

   if (STAGES < 2) begin : g_bad_stages
      $error("cfgser_sync: STAGES must be at least 2");
   end

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[0] <= RST_VAL;
            else        stg[0] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[i] <= RST_VAL;
            else        stg[i] <= stg[i-1];
         end
      end
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/cfgser_frame.sv
module cfgser_frame #(
   parameter int FRAME_W = cfgser_pkg::FRAME_W,
   parameter int ADDR_W  = cfgser_pkg::ADDR_W,
   parameter int DATA_W  = cfgser_pkg::DATA_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               en_n_s,
   input  logic               sclk_s,
   input  logic               sdat_s,
   output logic               wr_valid,
   output logic [FRAME_W-1:0] wr_word
);
   localparam int CNT_W = $clog2(FRAME_W + 1);
   localparam logic [CNT_W-1:0] FULL = CNT_W'(FRAME_W);

   if (FRAME_W <= ADDR_W + DATA_W) begin : g_bad_frame
      $error("cfgser_frame: FRAME_W must exceed ADDR_W + DATA_W");
   end

   logic               sclk_d, en_d;
   logic [CNT_W-1:0]   cnt;
   logic [FRAME_W-1:0] shreg;
   logic               sclk_rise, en_rise;

   assign sclk_rise = sclk_s & ~sclk_d;
   assign en_rise   = en_n_s & ~en_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_d   <= 1'b0;
         en_d     <= 1'b1;
         cnt      <= '0;
         shreg    <= '0;
         wr_valid <= 1'b0;
         wr_word  <= '0;
      end else begin
         sclk_d   <= sclk_s;
         en_d     <= en_n_s;
         wr_valid <= en_rise && (cnt == FULL);
         if (en_rise && (cnt == FULL)) wr_word <= shreg;
         if (en_n_s) begin
            cnt <= '0;
         end else if (sclk_rise) begin
            shreg <= {shreg[FRAME_W-2:0], sdat_s};
            if (cnt != FULL) cnt <= cnt + 1'b1;
         end
      end
   end

   // R3
   commit_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_valid |=> !wr_valid);
   // R3
   no_commit_in_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !en_n_s |=> !wr_valid);
   // R4
   count_saturate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt == FULL && !en_n_s) |=> (cnt == FULL || en_n_s));
   // R2
   count_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!sclk_rise && !en_n_s) |=> (cnt == $past(cnt) || en_n_s));
endmodule

// File: rtl/cfgser_bank.sv
module cfgser_bank #(
   parameter int FRAME_W = cfgser_pkg::FRAME_W,
   parameter int ADDR_W  = cfgser_pkg::ADDR_W,
   parameter int DATA_W  = cfgser_pkg::DATA_W,
   parameter int NREG    = cfgser_pkg::NREG,
   parameter int RUN_BIT = cfgser_pkg::CTL_RUN
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       wr_valid,
   input  logic [FRAME_W-1:0]         wr_word,
   output logic [NREG-1:0][DATA_W-1:0] regs_o
);
   localparam int IDX_W = $clog2(NREG);

   if (NREG < 2 || NREG > (1 << ADDR_W)) begin : g_bad_nreg
      $error("cfgser_bank: NREG must lie in 2 .. 2**ADDR_W");
   end

   logic [ADDR_W-1:0] wr_addr;
   logic [DATA_W-1:0] wr_data;
   logic [DATA_W-1:0] regs [NREG];
   logic [NREG-1:0][DATA_W-1:0] dflt;
   logic              run, others_dflt, addr_hit;
   logic              unused_pad;

   assign wr_addr    = wr_word[DATA_W +: ADDR_W];
   assign wr_data    = wr_word[DATA_W-1:0];
   assign unused_pad = ^wr_word[FRAME_W-1:DATA_W+ADDR_W];
   assign run        = regs[0][RUN_BIT];
   assign addr_hit   = int'(wr_addr) < NREG;

   for (genvar g = 0; g < NREG; g++) begin : g_reg
      assign dflt[g]   = cfgser_pkg::reg_default(g);
      assign regs_o[g] = regs[g];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < NREG; i++) regs[i] <= dflt[i];
      end else if (wr_valid) begin
         if (wr_addr == '0) begin
            regs[0] <= wr_data;
            if (!wr_data[RUN_BIT])
               for (int i = 1; i < NREG; i++) regs[i] <= dflt[i];
         end else if (run && addr_hit) begin
            regs[wr_addr[IDX_W-1:0]] <= wr_data;
         end
      end
   end

   always_comb begin
      others_dflt = 1'b1;
      for (int i = 1; i < NREG; i++)
         if (regs_o[i] != dflt[i]) others_dflt = 1'b0;
   end

   // R6
   hold_dflt_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !run |-> others_dflt);
   // R7
   soft_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_valid && wr_addr == '0 && !wr_data[RUN_BIT]) |=> (others_dflt && !run));
   // R10
   bank_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_valid || !addr_hit) |=> (regs_o == $past(regs_o)));
endmodule

// File: rtl/cfgser_port.sv
module cfgser_port #(
   parameter int SYNC_STAGES = 2,
   parameter int FRAME_W     = cfgser_pkg::FRAME_W,
   parameter int ADDR_W      = cfgser_pkg::ADDR_W,
   parameter int DATA_W      = cfgser_pkg::DATA_W,
   parameter int NREG        = cfgser_pkg::NREG
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       ser_en_n,
   input  logic       ser_clk,
   input  logic       ser_dat,
   output logic       out_en_n,
   output logic       run,
   output logic       drive_x2,
   output logic       cds_mode,
   output logic [1:0] ft_pos,
   output logic       dual_edge,
   output logic       power_up,
   output logic [7:0] offset_code,
   output logic [5:0] gain_code,
   output logic       tsmp_sample,
   output logic [1:0] shd_width,
   output logic       split_order
);
   import cfgser_pkg::*;

   if (DATA_W != 8 || NREG != 4) begin : g_bad_map
      $error("cfgser_port: field map assumes four 8-bit registers");
   end

   logic [2:0]                   lines_s;
   logic                         wr_valid;
   logic [FRAME_W-1:0]           wr_word;
   logic [NREG-1:0][DATA_W-1:0]  regs;
   logic                         unused_rsvd;

   cfgser_sync #(
      .STAGES (SYNC_STAGES),
      .WIDTH  (3),
      .RST_VAL(3'b100)
   ) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d    ({ser_en_n, ser_clk, ser_dat}),
      .q    (lines_s)
   );

   cfgser_frame #(
      .FRAME_W(FRAME_W),
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W)
   ) u_frame (
      .clk     (clk),
      .rst_n   (rst_n),
      .en_n_s  (lines_s[2]),
      .sclk_s  (lines_s[1]),
      .sdat_s  (lines_s[0]),
      .wr_valid(wr_valid),
      .wr_word (wr_word)
   );

   cfgser_bank #(
      .FRAME_W(FRAME_W),
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W),
      .NREG   (NREG),
      .RUN_BIT(CTL_RUN)
   ) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_valid(wr_valid),
      .wr_word (wr_word),
      .regs_o  (regs)
   );

   assign out_en_n    = ser_en_n;
   assign run         = regs[0][CTL_RUN];
   assign drive_x2    = regs[0][CTL_DRV];
   assign cds_mode    = regs[0][CTL_CDS];
   assign ft_pos      = regs[0][CTL_FT_LSB +: 2];
   assign dual_edge   = regs[0][CTL_DUAL];
   assign power_up    = regs[0][CTL_PWR];
   assign offset_code = regs[1];
   assign gain_code   = regs[2][GAIN_W-1:0];
   assign tsmp_sample = regs[3][SMP_TSMP];
   assign shd_width   = regs[3][SMP_W_LSB +: 2];
   assign split_order = regs[3][SMP_SPLIT];
   assign unused_rsvd = ^{regs[0][6], regs[2][7:6], regs[3][7:6], regs[3][2:1]};
endmodule

// File: tb/cfgser_port_tb.sv
module cfgser_port_tb;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ser_en_n = 1'b1, ser_clk = 1'b0, ser_dat = 1'b0;
   logic out_en_n, run, drive_x2, cds_mode, dual_edge, power_up;
   logic tsmp_sample, split_order;
   logic [1:0] ft_pos, shd_width;
   logic [7:0] offset_code;
   logic [5:0] gain_code;

   int total = 0;
   int fails = 0;
   logic [7:0] m [4];

   always #4 clk = ~clk;

   cfgser_port u_dut (
      .clk(clk), .rst_n(rst_n), .ser_en_n(ser_en_n), .ser_clk(ser_clk),
      .ser_dat(ser_dat), .out_en_n(out_en_n), .run(run), .drive_x2(drive_x2),
      .cds_mode(cds_mode), .ft_pos(ft_pos), .dual_edge(dual_edge),
      .power_up(power_up), .offset_code(offset_code), .gain_code(gain_code),
      .tsmp_sample(tsmp_sample), .shd_width(shd_width), .split_order(split_order)
   );

   function automatic logic [24:0] expv();
      return {m[0][7], m[0][5], m[0][4], m[0][3:2], m[0][1], m[0][0],
              m[1], m[2][5:0], m[3][5], m[3][4:3], m[3][0]};
   endfunction

   function automatic logic [24:0] actv();
      return {run, drive_x2, cds_mode, ft_pos, dual_edge, power_up,
              offset_code, gain_code, tsmp_sample, shd_width, split_order};
   endfunction

   function automatic void model_reset();
      m[0] = 8'h00; m[1] = 8'h80; m[2] = 8'h00; m[3] = 8'h00;
   endfunction

   function automatic void model_write(logic [2:0] a, logic [7:0] d);
      if (a == 3'd0) begin
         m[0] = d;
         if (!d[7]) begin m[1] = 8'h80; m[2] = 8'h00; m[3] = 8'h00; end
      end else if (a < 3'd4 && m[0][7]) begin
         m[a[1:0]] = d;
      end
   endfunction

   task automatic tick(int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic check(string req, string what);
      logic [24:0] a, e;
      a = actv();
      e = expv();
      total++;
      if (a !== e) begin
         fails++;
         $display("FAIL %s %s: actual %h expected %h", req, what, a, e);
      end
   endtask

   task automatic check_bit(string req, string what, logic a, logic e);
      total++;
      if (a !== e) begin
         fails++;
         $display("FAIL %s %s: actual %b expected %b", req, what, a, e);
      end
   endtask

   // sends the low n bits, MSB first; early: check outputs before enable rises
   task automatic send(logic [31:0] bits, int n, bit early = 1'b0);
      logic [15:0] w;
      ser_en_n = 1'b0;
      tick(3);
      for (int i = n - 1; i >= 0; i--) begin
         ser_dat = bits[i];
         tick(2);
         ser_clk = 1'b1;
         tick(3);
         ser_clk = 1'b0;
         tick(1);
      end
      tick(6);
      if (early) check("R3", "no commit before enable rises");
      ser_en_n = 1'b1;
      tick(8);
      if (n >= 16) begin
         w = bits[15:0];
         model_write(w[10:8], w[7:0]);
      end
   endtask

   function automatic logic [31:0] frm(logic [2:0] a, logic [7:0] d);
      return {16'h0000, 5'b00000, a, d};
   endfunction

   initial begin
      tick(200000);
      fails++;
      total++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end

   initial begin
      void'($urandom(32'd1234));
      model_reset();
      tick(5);
      rst_n = 1'b1;
      tick(2);
      check("R1", "reset defaults");

      send(frm(3'd1, 8'h11), 16);
      check("R6", "write ignored while run low");

      send(frm(3'd0, 8'h81), 16);
      check("R8", "run and power up");

      send(frm(3'd1, 8'h3C), 16);
      check("R9", "offset write");
      send(frm(3'd2, 8'hFF), 16);
      check("R9", "gain keeps low six bits");
      send(frm(3'd3, 8'h39), 16);
      check("R9", "sample control fields");

      send(frm(3'd0, 8'hBE), 16, 1'b1);
      check("R8", "control fields after enable rise");
      check("R13", "address and data positions");

      send({12'h000, 4'b1011, frm(3'd1, 8'hA5)}[31:0], 20);
      check("R4", "last sixteen of twenty edges");

      send(frm(3'd1, 8'h5A) >> 1, 15);
      check("R5", "fifteen edges drop the frame");

      send(frm(3'd5, 8'hFF), 16);
      check("R10", "address five no effect");
      send(frm(3'd7, 8'h00), 16);
      check("R10", "address seven no effect");

      send(frm(3'd0, 8'h80), 16);
      check("R11", "power down keeps contents");

      for (int k = 0; k < 6; k++) begin
         ser_dat = k[0];
         tick(2); ser_clk = 1'b1; tick(3); ser_clk = 1'b0; tick(1);
      end
      tick(8);
      check("R2", "clock edges with enable high");

      ser_en_n = 1'b0;
      tick(1);
      check_bit("R12", "enable mirror low", out_en_n, 1'b0);
      ser_en_n = 1'b1;
      tick(1);
      check_bit("R12", "enable mirror high", out_en_n, 1'b1);
      tick(6);

      send(frm(3'd0, 8'h00), 16);
      check("R7", "soft reset restores defaults");
      send(frm(3'd2, 8'h22), 16);
      check("R6", "gain write ignored after soft reset");

      for (int k = 0; k < 60; k++) begin
         logic [2:0]  a;
         logic [7:0]  d;
         logic [31:0] b;
         int          n;
         n = 14 + int'($urandom % 8);
         a = 3'($urandom % 8);
         d = 8'($urandom);
         if (a == 3'd0) d[7] = ($urandom % 5) != 0;
         b = {16'($urandom), 5'b00000, a, d};
         send(b, n);
         check(n >= 16 ? "R4" : "R5", "random frame");
      end

      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end
endmodule